// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the peripheral end of a three-wire synchronous control bus that also has a chip select. Each access swaps one byte in both directions at once. The host's command byte is shifted into the port while the port's status byte is shifted out. When the host deselects the port after exactly eight serial clocks, the port presents the received byte on a parallel command output with a one-cycle strobe. The all-ones byte is treated as a no-operation, so the host can read status without issuing a command.

The port also requests service through an open-drain interrupt. The request is raised whenever the parallel status input changes value. It is released on the first rising serial clock of the next access. The serial pins are asynchronous to the block. They pass through a synchronizer into the system clock, and every serial event takes effect on the third rising `clk_i` edge after the pin changes. The serial clock idles low. Data bits travel most significant bit first.

Top module: `ser_ctl_port`

## Requirements
- R1: `sdo_oe_o` is 0 while the port is deselected and 1 while it is selected. It follows a change of `cs_ni` within 3 `clk_i` cycles.
- R2: On the falling edge of `cs_ni`, the value on `stat_i` is captured as the byte to return. Its bit 7 appears on `sdo_o` before the first rising serial clock.
- R3: `sdi_i` is sampled on each rising edge of `sclk_i`. The first bit sampled becomes bit 7 of the received command.
- R4: `sdo_o` advances by one bit on each falling edge of `sclk_i`, from bit 7 down to bit 0 of the captured status. After the eighth falling edge it shows 0.
- R5: Whenever `stat_i` differs from its value one `clk_i` cycle earlier, `irq_pull_o` becomes 1 (line pulled low) and stays there.
- R6: A pending request is cleared only by the first rising `sclk_i` edge after select. Later edges in the same access do not clear it. A status change in the same cycle as that clear keeps the request asserted.
- R7: When `cs_ni` rises after exactly 8 rising serial clocks, `cmd_stb_o` is 1 for one `clk_i` cycle and `cmd_o` holds the received byte. Any other count gives no strobe.
- R8: A received byte of 8'hFF produces no strobe, and `cmd_o` keeps its previous value.
- R9: Serial clock edges while `cs_ni` is high change no output. They do not release a pending interrupt, and they produce no strobe.
- R10: After reset, `sdo_oe_o`, `irq_pull_o` and `cmd_stb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select from host |
| sclk_i | input | 1 | Serial clock from host, idle low |
| sdi_i | input | 1 | Serial command data from host |
| sdo_o | output | 1 | Serial status data to host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |
| irq_pull_o | output | 1 | 1 pulls the open-drain interrupt line low |
| cmd_o | output | DATA_W | Last accepted command byte |
| cmd_stb_o | output | 1 | One-cycle strobe for a new command |
| stat_i | input | DATA_W | Parallel status to report |

## Verification
Two events can meet in the same cycle. One is the interrupt release from the first rising serial clock of an access. The other is a new status change that must raise the request again. The bench drives `stat_i` two system cycles after it raises `sclk_i`, so both events land on the same register edge once the synchronizer delay is counted. The reference model then expects `irq_pull_o` to stay asserted through the whole access and beyond. A design that gives the release priority drops the line and loses the change for good.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic start;  // select asserted
    logic stop;   // select released
    logic rise;   // serial clock rising
    logic fall;   // serial clock falling
  } port_evt_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_front.sv
module ser_front
  import ser_port_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_ni,
  input  logic      sclk_i,
  input  logic      sdi_i,
  output port_evt_t evt_o,
  output logic      sdi_o
);
  localparam logic [2:0] PIN_RST = 3'b100;  // cs high, sclk low, sdi low

  logic [2:0] pins_s;
  logic       cs_d, sclk_d;

  ser_sync #(
    .W      (3),
    .STAGES (STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= pins_s[2];
      sclk_d <= pins_s[1];
    end
  end

  assign evt_o.start = cs_d & ~pins_s[2];
  assign evt_o.stop  = ~cs_d & pins_s[2];
  assign evt_o.rise  = ~sclk_d & pins_s[1];
  assign evt_o.fall  = sclk_d & ~pins_s[1];
  assign sdi_o       = pins_s[0];
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_port_pkg::*;
#(
  parameter int unsigned  DATA_W   = BYTE_W,
  parameter logic [DATA_W-1:0] NOP_CODE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_evt_t         evt_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_stb_o,
  output logic              first_rise_o
);
  localparam int unsigned  CNT_W   = $clog2(DATA_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q, cmd_q;
  logic              stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      cmd_q    <= '0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (evt_i.start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tx_q     <= stat_i;
      end else if (active_q) begin
        if (evt_i.stop) begin
          active_q <= 1'b0;
          if (cnt_q == CNT_END && rx_q != NOP_CODE) begin
            cmd_q <= rx_q;
            stb_q <= 1'b1;
          end
        end else begin
          if (evt_i.rise) begin
            rx_q <= {rx_q[DATA_W-2:0], sdi_i};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate: long bursts never alias to 8
          end
          if (evt_i.fall) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o        = active_q & tx_q[DATA_W-1];
  assign sdo_oe_o     = active_q;
  assign cmd_o        = cmd_q;
  assign cmd_stb_o    = stb_q;
  assign first_rise_o = active_q & evt_i.rise & ~evt_i.stop & (cnt_q == '0);

  // R4: status shifter moves only on a falling serial clock or a new select
  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.fall && !evt_i.start) |=> $stable(tx_q));

  // R9: deselected port keeps its count and received bits
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !evt_i.start) |=> ($stable(cnt_q) && $stable(rx_q)));

  // R7: a strobe only follows a completed deselect
  a_r7_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> !active_q);

  // R8: the no-operation byte never reaches the command output
  a_r8_no_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> (cmd_o != NOP_CODE));
endmodule

// File: rtl/ser_irq.sv
module ser_irq #(
  parameter int unsigned DATA_W = ser_port_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              first_rise_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] stat_q;
  logic              pend_q;
  logic              changed;

  assign changed = (stat_i != stat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_i;
      pend_q <= changed | (pend_q & ~first_rise_i);  // new change wins over release
    end
  end

  assign irq_o = pend_q;

  // R5: any status change raises the request
  a_r5_change_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |=> irq_o);

  // R6: only the first rising serial clock after select releases it
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !first_rise_i) |=> irq_o);
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_port_pkg::*;
#(
  parameter int unsigned DATA_W      = BYTE_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              irq_pull_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_stb_o,
  input  logic [DATA_W-1:0] stat_i
);
  localparam logic [DATA_W-1:0] NOP_CODE = '1;

  port_evt_t evt;
  logic      sdi_s;
  logic      first_rise;

  ser_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_ni),
    .sclk_i(sclk_i),
    .sdi_i (sdi_i),
    .evt_o (evt),
    .sdi_o (sdi_s)
  );

  ser_shift #(.DATA_W(DATA_W), .NOP_CODE(NOP_CODE)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .sdi_i       (sdi_s),
    .stat_i      (stat_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .cmd_o       (cmd_o),
    .cmd_stb_o   (cmd_stb_o),
    .first_rise_o(first_rise)
  );

  ser_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stat_i      (stat_i),
    .first_rise_i(first_rise),
    .irq_o       (irq_pull_o)
  );

  // R1: releasing select floats the data line on the next edge
  a_r1_float_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.stop |=> !sdo_oe_o);
endmodule

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;      // clk_i cycles per serial half period
  localparam int LAT   = 3;      // pin change to output change
  localparam int WDOG  = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni, cs_ni, sclk_i, sdi_i;
  logic [7:0] stat_i;
  logic       sdo_o, sdo_oe_o, irq_pull_o, cmd_stb_o;
  logic [7:0] cmd_o;

  ser_ctl_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .irq_pull_o(irq_pull_o),
    .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o), .stat_i(stat_i)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int   cyc = 0, last_chg = 0, checks = 0, errors = 0, stb_cnt = 0;
  logic [7:0] last_cmd = 8'h00;
  logic exp_oe = 1'b0, exp_irq = 1'b0, exp_sdo = 1'b0;

  task automatic touch(); last_chg = cyc; endtask
  task automatic wait_n(int n); repeat (n) @(negedge clk_i); endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle comparison against the behavioural model
  always begin
    @(posedge clk_i);
    #(CLK_P/4);
    cyc++;
    if (cmd_stb_o) begin stb_cnt++; last_cmd = cmd_o; end
    if (rst_ni && (cyc - last_chg) >= LAT) begin
      check_int("R1 sdo_oe", int'(sdo_oe_o), int'(exp_oe));
      check_int("R5/R6 irq", int'(irq_pull_o), int'(exp_irq));
      if (exp_oe) check_int("R2/R4 sdo", int'(sdo_o), int'(exp_sdo));
    end
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic set_stat(logic [7:0] v);
    if (v != stat_i) exp_irq = 1'b1;
    stat_i = v;
    touch();
  endtask

  // one access; optional status change mid-frame or coincident with first rise
  task automatic xfer(logic [7:0] cmd, int nbits, bit mid, logic [7:0] mid_v,
                      bit coin, logic [7:0] coin_v);
    logic [7:0] cap;
    int s0;
    cap = stat_i;
    s0  = stb_cnt;
    @(negedge clk_i);
    cs_ni = 1'b0; exp_oe = 1'b1; exp_sdo = cap[7]; touch();
    wait_n(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi_i = (i < 8) ? cmd[7-i] : 1'b0;
      wait_n(HALF);
      sclk_i = 1'b1; touch();
      if (i == 0 && !coin) exp_irq = 1'b0;
      if (i == 0 && coin) begin
        wait_n(2);
        stat_i = coin_v; exp_irq = 1'b1; touch();   // lands on the release edge
        wait_n(HALF - 2);
      end else begin
        wait_n(HALF);
      end
      sclk_i = 1'b0;
      exp_sdo = (i + 1 < 8) ? cap[6-i] : 1'b0;
      touch();
      wait_n(HALF);
      if (mid && i == 3) begin stat_i = mid_v; exp_irq = 1'b1; touch(); end
    end
    cs_ni = 1'b1; exp_oe = 1'b0; touch();
    wait_n(8);
    if (nbits == 8 && cmd != 8'hFF) begin
      check_int("R7 strobe count", stb_cnt - s0, 1);
      check_int("R3 command byte", int'(last_cmd), int'(cmd));
    end else if (cmd == 8'hFF) begin
      check_int("R8 no strobe for no-op", stb_cnt - s0, 0);
    end else begin
      check_int("R7 no strobe on bad count", stb_cnt - s0, 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; cs_ni = 1'b1; sclk_i = 1'b0; sdi_i = 1'b0; stat_i = 8'h00;
    wait_n(5);
    rst_ni = 1'b1; touch();
    wait_n(6);
    check_int("R10 reset oe", int'(sdo_oe_o), 0);
    check_int("R10 reset irq", int'(irq_pull_o), 0);
    check_int("R10 reset strobe", stb_cnt, 0);

    set_stat(8'hA5); wait_n(6);
    check_int("R5 irq on change", int'(irq_pull_o), 1);
    xfer(8'h3C, 8, 0, 8'h00, 0, 8'h00);
    check_int("R6 irq released", int'(irq_pull_o), 0);

    set_stat(8'h5A); wait_n(6);
    xfer(8'hFF, 8, 0, 8'h00, 0, 8'h00);
    check_int("R8 cmd kept", int'(cmd_o), 8'h3C);
    xfer(8'h81, 7, 0, 8'h00, 0, 8'h00);
    xfer(8'h81, 9, 0, 8'h00, 0, 8'h00);
    xfer(8'hC3, 8, 0, 8'h00, 0, 8'h00);

    set_stat(8'h0F); wait_n(6);
    for (int k = 0; k < 6; k++) begin
      sclk_i = ~sclk_i; touch(); wait_n(HALF);
    end
    wait_n(6);
    check_int("R9 irq kept while idle", int'(irq_pull_o), 1);
    check_int("R9 oe idle", int'(sdo_oe_o), 0);
    check_int("R9 no idle strobe", int'(cmd_o), 8'hC3);

    xfer(8'h66, 8, 1, 8'hF0, 0, 8'h00);
    check_int("R6 mid-frame change pending", int'(irq_pull_o), 1);
    xfer(8'h99, 8, 0, 8'h00, 1, 8'h11);
    check_int("R6 coincident change kept", int'(irq_pull_o), 1);
    xfer(8'h24, 8, 0, 8'h00, 0, 8'h00);
    check_int("R6 released later", int'(irq_pull_o), 0);

    wait_n(10);
    summary();
  end
endmodule